// File: doc/BRIEF.md
# Periodic Interrupt Down Timer

This block is a reloading down-counter that paces periodic interrupt events from a slow time base. The system clock runs the logic. A one-cycle `tick_i` strobe marks each period of the 32768 Hz reference. Software stores a reload value, which is 32768 divided by the wanted event rate in Hz. Software then sets the run bit. The counter steps down once per tick. When it reaches the end of the count it pulses `expire_o` and refills from the reload value. The pulse feeds the raw periodic status bit in a shared interrupt register block, which owns masking and clearing.

Writes arrive on a valid/ready port. A write completes on a clock edge where both `wr_valid_i` and `wr_ready_o` are high. `wr_ready_o` drops only when the presented address is the control register and the control hold-off is still open. The hold-off opens on every accepted control write and closes after one time-base tick. While it is open, the sender must keep the control write pending, or retry it later. Writes to the other offsets are never stalled. Reads are combinational from `rd_addr_i`.

The reload value is locked while the timer runs. An optional auto-start bit lets a single reload write also start the timer.

Top module: `pit_timer`

## Requirements
- R1: After reset the count, reload and control registers all read 0, `expire_o` is low, and `wr_ready_o` is high for a control write.
- R2: Writing the control register (byte offset 0x28) with bit 1 (run) set while the timer is stopped copies the reload value into the count. Each following tick lowers the count by one. The tick that finds the count at 1 pulses `expire_o` high for one clock and restores the count to the reload value, so the first event comes exactly reload-value ticks after the start.
- R3: While the timer runs, events repeat every reload-value ticks with no drift. A reload value of 1 gives an event on every tick.
- R4: A write to the reload register (offset 0x24) while run is set is accepted on the port but has no effect: the reload readback and the event period are unchanged.
- R5: When control bit 0 (auto-start) is set and the timer is stopped, a nonzero write to the reload register stores the value, loads it into the count, and sets run in the same clock.
- R6: Writing run = 0 stops the timer. The count holds its value and no events occur on later ticks.
- R7: After an accepted control write, `wr_ready_o` is low for control-address writes until one tick has been seen. A control write presented then is not taken. Reload-address writes stay ready throughout.
- R8: A reload value of 0 produces no events even with run set, and the count stays 0. An auto-start write of 0 does not set run.
- R9: Without a tick, and with no write that loads the count, the count does not change and `expire_o` stays low.
- R10: The count register (offset 0x20) is read-only. Writes to it are accepted and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-clock strobe per 32768 Hz period |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write can be taken this clock |
| wr_addr_i | input | 8 | Write byte offset: 0x20 count, 0x24 reload, 0x28 control |
| wr_data_i | input | WIDTH | Write data; control uses bit 0 auto-start and bit 1 run |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | WIDTH | Read data; control reads back bits 1:0, upper bits zero |
| expire_o | output | 1 | One-clock pulse per expiry, the periodic interrupt request |

## Verification
A wrong count or a stale reload value shows on `expire_o` within one period. The event lands on the wrong tick, and the count readback taken after each tick departs from the value computed from the reload value and the number of ticks. A lost run bit or a broken lock shows on the next tick as a missing or extra event, or as a reload readback that changed. A faulty hold-off shows at once on `wr_ready_o` in the clock after a control write.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h28;
  localparam int CTRL_AUTO_BIT = 0;
  localparam int CTRL_RUN_BIT  = 1;
endpackage

// File: rtl/pit_wr_gate.sv
module pit_wr_gate
  import pit_pkg::*;
#(
  parameter int HOLD_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              wr_ready_o,
  output logic              acc_load_o,
  output logic              acc_ctrl_o
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HW-1:0] hold_q;
  logic          is_ctrl;
  logic          accept;

  assign is_ctrl    = (wr_addr_i == OFS_CTRL);
  assign wr_ready_o = !(is_ctrl && (hold_q != '0));
  assign accept     = wr_valid_i && wr_ready_o;
  assign acc_ctrl_o = accept && is_ctrl;
  assign acc_load_o = accept && (wr_addr_i == OFS_LOAD);

  // Hold-off: a control write reopens the window; ticks close it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (acc_ctrl_o) begin
      hold_q <= HW'(HOLD_TICKS);
    end else if (tick_i && (hold_q != '0)) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  assert_ctrl_backpressure_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    acc_ctrl_o |=> ((wr_addr_i != OFS_CTRL) || !wr_ready_o));

  assert_load_never_stalls_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr_i == OFS_LOAD) |-> wr_ready_o);
endmodule

// File: rtl/pit_ctrl_regs.sv
module pit_ctrl_regs
  import pit_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_load_i,
  input  logic             acc_ctrl_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] load_o,
  output logic             run_o,
  output logic             auto_o,
  output logic             preset_o,
  output logic [WIDTH-1:0] preset_val_o
);
  logic load_ok;
  logic start_by_ctrl;
  logic start_by_load;

  // Reload is writable only while stopped.
  assign load_ok       = acc_load_i && !run_o;
  assign start_by_ctrl = acc_ctrl_i && wdata_i[CTRL_RUN_BIT] && !run_o;
  assign start_by_load = load_ok && auto_o && (wdata_i != '0);

  always_comb begin
    preset_o     = 1'b0;
    preset_val_o = load_o;
    if (load_ok) begin
      preset_o     = 1'b1;
      preset_val_o = wdata_i;
    end else if (start_by_ctrl) begin
      preset_o     = 1'b1;
      preset_val_o = load_o;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_o <= '0;
      run_o  <= 1'b0;
      auto_o <= 1'b0;
    end else begin
      if (load_ok) load_o <= wdata_i;
      if (acc_ctrl_i) begin
        run_o  <= wdata_i[CTRL_RUN_BIT];
        auto_o <= wdata_i[CTRL_AUTO_BIT];
      end else if (start_by_load) begin
        run_o <= 1'b1;
      end
    end
  end

  assert_load_locked_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    run_o |=> $stable(load_o));

  assert_autostart_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (acc_load_i && auto_o && !run_o && (wdata_i != '0)) |=> run_o);

  assert_zero_autostart_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (acc_load_i && !acc_ctrl_i && !run_o && (wdata_i == '0)) |=> !run_o);
endmodule

// File: rtl/pit_downcount.sv
module pit_downcount #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [WIDTH-1:0] load_i,
  input  logic             preset_i,
  input  logic [WIDTH-1:0] preset_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             expire_o
);
  logic active;
  logic at_end;

  assign active = run_i && (load_i != '0);
  assign at_end = (count_o <= WIDTH'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o  <= '0;
      expire_o <= 1'b0;
    end else if (preset_i) begin
      count_o  <= preset_val_i;
      expire_o <= 1'b0;
    end else if (tick_i && active) begin
      count_o  <= at_end ? load_i : count_o - 1'b1;
      expire_o <= at_end;
    end else begin
      expire_o <= 1'b0;
    end
  end

  assert_expire_reloads_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (count_o == load_i));

  assert_count_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !preset_i) |=> ($stable(count_o) && !expire_o));

  assert_stopped_silent_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !expire_o);

  assert_zero_load_silent_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (load_i == '0) |=> !expire_o);
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int HOLD_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WIDTH-1:0]  rd_data_o,
  output logic              expire_o
);
  logic             acc_load;
  logic             acc_ctrl;
  logic [WIDTH-1:0] load_val;
  logic             run;
  logic             auto_start;
  logic             preset;
  logic [WIDTH-1:0] preset_val;
  logic [WIDTH-1:0] count_val;

  pit_wr_gate #(.HOLD_TICKS(HOLD_TICKS)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .wr_ready_o (wr_ready_o),
    .acc_load_o (acc_load),
    .acc_ctrl_o (acc_ctrl)
  );

  pit_ctrl_regs #(.WIDTH(WIDTH)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_load_i   (acc_load),
    .acc_ctrl_i   (acc_ctrl),
    .wdata_i      (wr_data_i),
    .load_o       (load_val),
    .run_o        (run),
    .auto_o       (auto_start),
    .preset_o     (preset),
    .preset_val_o (preset_val)
  );

  pit_downcount #(.WIDTH(WIDTH)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .run_i        (run),
    .load_i       (load_val),
    .preset_i     (preset),
    .preset_val_i (preset_val),
    .count_o      (count_val),
    .expire_o     (expire_o)
  );

  always_comb begin
    case (rd_addr_i)
      OFS_COUNT: rd_data_o = count_val;
      OFS_LOAD:  rd_data_o = load_val;
      OFS_CTRL:  rd_data_o = {{(WIDTH-2){1'b0}}, run, auto_start};
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  localparam logic [7:0] A_CNT  = 8'h20;
  localparam logic [7:0] A_LOAD = 8'h24;
  localparam logic [7:0] A_CTRL = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        expire;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .expire_o(expire)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d, output logic took);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1 took = wr_ready;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a; #1 v = rd_data;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic took;
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_LOAD, v); chk("R1 load", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    chk("R1 expire", expire, 0);
    wr_addr = A_CTRL; #1 chk("R1 ready", wr_ready, 1);

    // R2 R3: sweep reload values, three periods each
    for (int L = 1; L <= 7; L++) begin
      do_wr(A_CTRL, 0, took);
      do_tick();
      do_wr(A_LOAD, L, took);
      rd(A_LOAD, v); chk("R2 load readback", v, L);
      do_wr(A_CTRL, 2, took);
      rd(A_CNT, v); chk("R2 start count", v, L);
      for (int k = 1; k <= 3 * L; k++) begin
        do_tick();
        rd(A_CNT, v);
        chk("R3 count", v, (k % L == 0) ? L : L - (k % L));
        chk("R2 expire", expire, (k % L == 0) ? 1 : 0);
      end
    end

    // R4: reload write ignored while running (reload is 7, count 7)
    do_wr(A_LOAD, 3, took);
    chk("R4 write taken", took, 1);
    rd(A_LOAD, v); chk("R4 load kept", v, 7);
    for (int k = 1; k <= 7; k++) begin
      do_tick();
      chk("R4 period", expire, (k == 7) ? 1 : 0);
    end

    // R9: no tick, no change
    do_tick(); do_tick();
    rd(A_CNT, v); chk("R9 count", v, 5);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= expire; end
    rd(A_CNT, v); chk("R9 hold", v, 5);
    chk("R9 no expire", seen, 0);

    // R6 R7: stop, then hold-off
    do_wr(A_CTRL, 0, took);
    rd(A_CTRL, v); chk("R6 ctrl", v, 0);
    wr_addr = A_CTRL; #1 chk("R7 ctrl stalled", wr_ready, 0);
    wr_addr = A_LOAD; #1 chk("R7 load ready", wr_ready, 1);
    do_wr(A_CTRL, 2, took);
    chk("R7 not taken", took, 0);
    rd(A_CTRL, v); chk("R7 ctrl unchanged", v, 0);
    seen = 1'b0;
    for (int k = 0; k < 10; k++) begin do_tick(); seen |= expire; end
    chk("R6 no expire", seen, 0);
    rd(A_CNT, v); chk("R6 count frozen", v, 5);
    wr_addr = A_CTRL; #1 chk("R7 ready after tick", wr_ready, 1);

    // R10: count read-only
    do_wr(A_CNT, 3, took);
    rd(A_CNT, v); chk("R10 count", v, 5);

    // R5: auto-start
    do_wr(A_CTRL, 1, took);
    do_tick();
    do_wr(A_LOAD, 4, took);
    rd(A_CTRL, v); chk("R5 run set", v, 3);
    rd(A_CNT, v);  chk("R5 count", v, 4);
    for (int k = 1; k <= 4; k++) begin
      do_tick();
      chk("R5 expire", expire, (k == 4) ? 1 : 0);
    end

    // R8: zero reload
    do_wr(A_CTRL, 0, took);
    do_tick();
    do_wr(A_LOAD, 0, took);
    do_wr(A_CTRL, 2, took);
    rd(A_CTRL, v); chk("R8 run set", v, 2);
    seen = 1'b0;
    for (int k = 0; k < 10; k++) begin do_tick(); seen |= expire; end
    chk("R8 no expire", seen, 0);
    rd(A_CNT, v); chk("R8 count", v, 0);
    do_wr(A_CTRL, 1, took);
    do_tick();
    do_wr(A_LOAD, 0, took);
    rd(A_CTRL, v); chk("R8 zero autostart", v, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule